// File: doc/BRIEF.md
# Prioritized Local Bus Interrupt Controller

This block gathers up to sixteen level-sensitive request lines from local peripherals and turns them into a single interrupt for the processor. Each line is brought into the clock domain through a two-flop synchronizer. The synchronized level is the line's status bit, so a device clears its request simply by lowering its line. The status word is ANDed with a programmable enable mask, and the single interrupt output is high while any enabled line is pending.

Software reaches the block through a small 16-bit register port. A read-only vector register names the lowest-numbered pending line. The read/write enable mask sits beside it. Byte accesses merge into the addressed half-word. A 32-bit access is split into two half-word accesses at the given offset and the offset plus two. There are no edge-triggered sources, no nesting and no acknowledge cycle.

Top module: `lbus_irq_ctrl`

## Requirements
- R1: Each request line reaches its status bit through exactly two flip-flops. A line raised or lowered before a rising edge changes the interrupt output two rising edges later, and not one edge later.
- R2: The interrupt output is high exactly when the status word ANDed with the enable mask is nonzero.
- R3: A half-word read of offset 0x00 returns (i+1)*4, where i is the lowest-numbered line that is both pending and enabled. It returns 0 when no line is pending.
- R4: Offset 0x02 holds the enable mask. A half-word write there replaces it, and a read returns it. The interrupt output reflects the new mask from the write's clock edge onward.
- R5: After reset the enable mask reads 0x0010, the status word is zero and the interrupt output is low.
- R6: A byte write (size 2'b00) updates only the addressed byte of the half-word at offset addr with bit 0 cleared. Address bit 0 = 0 selects bits 7:0 and address bit 0 = 1 selects bits 15:8. The other byte keeps its value.
- R7: A byte read returns the addressed byte of that half-word in bits 7:0, with bits 31:8 zero.
- R8: A word access (size 2'b1x) uses the half-word at the base offset for bits 15:0 and the half-word at base+2 for bits 31:16, both for reads and for writes. A half-word access uses size 2'b01.
- R9: Writes to offset 0x00 or to any offset other than 0x02 leave the enable mask unchanged. Reads of any offset other than 0x00 and 0x02 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Level-sensitive request lines, bit i is line i |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | 00 byte, 01 half-word, 1x word |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data, low-aligned |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not selected |
| irq_o | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check four things. The status word trails the request pins by exactly two edges. The interrupt output agrees with the vector register. A half-word mask write lands on the next edge, and byte writes and writes to other offsets leave the bytes they do not address untouched. Only the bench scenarios can show the priority order across many request and mask patterns, the reset values, and how byte and word accesses lay the two registers out on the data bus.

// File: rtl/lbus_irq_ctrl.sv
module lbus_irq_ctrl #(
  parameter int          N_SRC    = 16,
  parameter int          ADDR_W   = 12,
  parameter int          SYNC_LEN = 2,
  parameter logic [15:0] MASK_RST = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] OFS_VEC  = '0;
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(2);

  logic [SYNC_LEN-1:0][N_SRC-1:0] sync_q;
  logic [N_SRC-1:0]  stat_q;
  logic [N_SRC-1:0]  mask_q;
  logic [N_SRC-1:0]  pend;
  logic [15:0]       src_vec;
  logic [15:0]       mask_ext;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] base_hi;
  logic [15:0]       half_lo;
  logic [15:0]       half_hi;
  logic              mask_wr;
  logic [15:0]       mask_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= req_i;
      for (int s = 1; s < SYNC_LEN; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign stat_q   = sync_q[SYNC_LEN-1];
  assign pend     = stat_q & mask_q;
  assign irq_o    = |pend;
  assign mask_ext = 16'(mask_q);

  always_comb begin
    src_vec = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) src_vec = (16'(i) + 16'd1) << 2;
  end

  function automatic logic [15:0] half_rd(input logic [ADDR_W-1:0] ofs,
                                          input logic [15:0] vec,
                                          input logic [15:0] msk);
    if (ofs == OFS_VEC)       return vec;
    else if (ofs == OFS_MASK) return msk;
    else                      return 16'h0000;
  endfunction

  assign base    = {bus_addr_i[ADDR_W-1:1], 1'b0};
  assign base_hi = base + ADDR_W'(2);
  assign half_lo = half_rd(base, src_vec, mask_ext);
  assign half_hi = half_rd(base_hi, src_vec, mask_ext);

  always_comb begin
    if (!bus_sel_i)         bus_rdata_o = '0;
    else if (bus_size_i[1]) bus_rdata_o = {half_hi, half_lo};
    else if (bus_size_i[0]) bus_rdata_o = {16'h0000, half_lo};
    else                    bus_rdata_o = {24'h0, bus_addr_i[0] ? half_lo[15:8] : half_lo[7:0]};
  end

  always_comb begin
    mask_wr  = 1'b0;
    mask_nxt = mask_ext;
    if (bus_sel_i && bus_we_i) begin
      if (bus_size_i[1]) begin
        if (base == OFS_MASK) begin
          mask_wr  = 1'b1;
          mask_nxt = bus_wdata_i[15:0];
        end else if (base_hi == OFS_MASK) begin
          mask_wr  = 1'b1;
          mask_nxt = bus_wdata_i[31:16];
        end
      end else if (base == OFS_MASK) begin
        mask_wr = 1'b1;
        if (bus_size_i[0])       mask_nxt = bus_wdata_i[15:0];
        else if (bus_addr_i[0])  mask_nxt = {bus_wdata_i[7:0], mask_ext[7:0]};
        else                     mask_nxt = {mask_ext[15:8], bus_wdata_i[7:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RST[N_SRC-1:0];
    else if (mask_wr) mask_q <= mask_nxt[N_SRC-1:0];
  end

endmodule

module lbus_irq_ctrl_chk #(
  parameter int N_SRC  = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  req_i,
  input logic [N_SRC-1:0]  stat_q,
  input logic [15:0]       mask_ext,
  input logic [15:0]       src_vec,
  input logic              irq_o,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [1:0]        bus_size_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i
);

  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  logic [ADDR_W-1:0] base;
  assign base = {bus_addr_i[ADDR_W-1:1], 1'b0};

  logic half_wr, byte_wr_hi, byte_wr_lo;
  assign half_wr    = bus_sel_i && bus_we_i && bus_size_i == 2'b01;
  assign byte_wr_lo = bus_sel_i && bus_we_i && bus_size_i == 2'b00 && base == ADDR_W'(2) && !bus_addr_i[0];
  assign byte_wr_hi = bus_sel_i && bus_we_i && bus_size_i == 2'b00 && base == ADDR_W'(2) &&  bus_addr_i[0];

  assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd2) |-> (stat_q == $past(req_i, 2)));

  assert_irq_vs_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (src_vec != 16'h0));

  assert_vector_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vec[1:0] == 2'b00) && (src_vec <= 16'(4 * N_SRC)));

  assert_mask_half_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_wr && base == ADDR_W'(2)) |=> (mask_ext[N_SRC-1:0] == $past(bus_wdata_i[N_SRC-1:0])));

  assert_byte_lo_keeps_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr_lo |=> (mask_ext[15:8] == $past(mask_ext[15:8])));

  assert_byte_hi_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr_hi |=> (mask_ext[7:0] == $past(mask_ext[7:0])));

  assert_other_half_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (half_wr && base != ADDR_W'(2)) |=> $stable(mask_ext));

endmodule

bind lbus_irq_ctrl lbus_irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .stat_q(stat_q),
  .mask_ext(mask_ext), .src_vec(src_vec), .irq_o(irq_o),
  .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_size_i(bus_size_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i)
);

// File: tb/lbus_irq_ctrl_bench.sv
module lbus_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int AW = 12;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  req = '0;
  logic          sel = 0, we = 0;
  logic [1:0]    size = 2'b01;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbus_irq_ctrl u_lbus_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_sel_i(sel), .bus_we_i(we),
    .bus_size_i(size), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; size = sz; wdata = d;
    @(posedge clk); #1;
    sel = 0; we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = a; size = sz;
    #1 d = rdata;
    sel = 0;
  endtask

  function automatic logic [31:0] exp_vec(input logic [N-1:0] r, input logic [N-1:0] m);
    logic [N-1:0] p = r & m;
    for (int i = 0; i < N; i++) if (p[i]) return 32'((i + 1) * 4);
    return 0;
  endfunction

  task automatic sweep_case(input logic [N-1:0] r, input logic [N-1:0] m);
    logic [31:0] d;
    wr(12'h002, 2'b01, {16'h0, m});
    @(negedge clk); req = r;
    repeat (3) @(posedge clk);
    rd(12'h000, 2'b01, d);
    check("R3 vector", d, exp_vec(r, m));
    check("R2 irq", {31'h0, irq}, {31'h0, |(r & m)});
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R5 reset state
    rd(12'h002, 2'b01, d); check("R5 mask reset", d, 32'h0010);
    rd(12'h000, 2'b01, d); check("R5 vector reset", d, 32'h0);
    check("R5 irq reset", {31'h0, irq}, 32'h0);

    // R1 two-edge latency on line 4 (enabled at reset)
    @(negedge clk) req = 16'h0010;
    @(posedge clk); #1 check("R1 rise after 1 edge", {31'h0, irq}, 32'h0);
    @(posedge clk); #1 check("R1 rise after 2 edges", {31'h0, irq}, 32'h1);
    @(negedge clk) req = 16'h0000;
    @(posedge clk); #1 check("R1 fall after 1 edge", {31'h0, irq}, 32'h1);
    @(posedge clk); #1 check("R1 fall after 2 edges", {31'h0, irq}, 32'h0);

    // R4 mask write takes effect on the write edge
    @(negedge clk) req = 16'h0100;
    repeat (3) @(posedge clk);
    #1 check("R4 masked line idle", {31'h0, irq}, 32'h0);
    wr(12'h002, 2'b01, 32'h0000_0100);
    check("R4 irq after enabling", {31'h0, irq}, 32'h1);
    rd(12'h002, 2'b01, d); check("R4 mask readback", d, 32'h0100);
    wr(12'h002, 2'b01, 32'h0000_0000);
    check("R4 irq after disabling", {31'h0, irq}, 32'h0);
    @(negedge clk) req = '0;

    // R9 ignored writes and zero reads
    wr(12'h002, 2'b01, 32'h0000_1234);
    wr(12'h000, 2'b01, 32'h0000_FFFF);
    rd(12'h002, 2'b01, d); check("R9 write to vector ignored", d, 32'h1234);
    wr(12'h008, 2'b01, 32'h0000_FFFF);
    wr(12'h003 + 12'h004, 2'b00, 32'h0000_00FF);
    rd(12'h002, 2'b01, d); check("R9 write to undefined ignored", d, 32'h1234);
    rd(12'h004, 2'b01, d); check("R9 undefined half read", d, 32'h0);
    rd(12'h006, 2'b10, d); check("R9 undefined word read", d, 32'h0);
    rd(12'h7FE, 2'b01, d); check("R9 far undefined read", d, 32'h0);

    // R6 byte merges, R7 byte reads
    wr(12'h002, 2'b00, 32'h0000_00A5);
    rd(12'h002, 2'b01, d); check("R6 low byte write", d, 32'h12A5);
    wr(12'h003, 2'b00, 32'h0000_005C);
    rd(12'h002, 2'b01, d); check("R6 high byte write", d, 32'h5CA5);
    rd(12'h002, 2'b00, d); check("R7 byte read low", d, 32'hA5);
    rd(12'h003, 2'b00, d); check("R7 byte read high", d, 32'h5C);

    // R8 word accesses
    @(negedge clk) req = 16'h0404;
    repeat (3) @(posedge clk);
    rd(12'h000, 2'b10, d); check("R8 word read at 0", d, 32'h5CA5_000C);
    rd(12'h001, 2'b00, d); check("R7 byte read vector high", d, 32'h00);
    rd(12'h000, 2'b00, d); check("R7 byte read vector low", d, 32'h0C);
    rd(12'h002, 2'b10, d); check("R8 word read at 2", d, 32'h0000_5CA5);
    wr(12'h000, 2'b10, 32'hBEEF_0000);
    rd(12'h002, 2'b01, d); check("R8 word write at 0 hits mask", d, 32'hBEEF);
    wr(12'h002, 2'b10, 32'h1111_3C3C);
    rd(12'h002, 2'b01, d); check("R8 word write at 2 hits mask", d, 32'h3C3C);
    rd(12'h000, 2'b01, d); check("R3 vector lowest of 2,10", d, 32'h000C);
    @(negedge clk) req = '0;

    // R2/R3 sweeps: singles, pairs, pseudo-random
    for (int i = 0; i < N; i++) sweep_case(16'(1) << i, 16'hFFFF);
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) sweep_case((16'(1) << i) | (16'(1) << j), 16'hFFFF);
    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 400; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      sweep_case(lf[15:0], lf[31:16]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule